// File: doc/BRIEF.md
# Storage Card Clock Generator

This block makes the card bus clock from the source clock. Software programs it through a single 32-bit configuration write port. The configuration word selects one of four clock modes and an 8-bit divider value. A third field is a half-rate select that matters only in the fast double-data-rate mode. The block offers a bypass mode, a single-data-rate divided mode, a double-data-rate divided mode, and a fast double-data-rate mode that can run at half the source rate. The double-data-rate modes read the divider differently: a zero divider gives a quarter of the source rate, and a nonzero value holds half of the wanted divisor.

A new setting waits as a pending command. It takes effect only at the end of a low phase of the card clock, so the block never emits a shortened high pulse. Every write that changes a field clears a clock-stable flag. The flag is set again once the new setting has produced two complete output periods, and software polls it through the read-back word.

Top module: `cardclk_gen`

## Requirements
- R1: The configuration word holds the divider in bits [15:8], the mode in bits [17:16] and the half-rate select in bit 18. The read-back word returns these fields as last written, returns the clock-stable flag in bit 7, and returns zero in every other bit.
- R2: Mode 1 passes the source clock straight through, so the card clock has a period of 1 source cycle whatever the divider value.
- R3: In mode 0 a divider N of zero gives a period of 2 source cycles, and a nonzero N gives a period of 4·N source cycles.
- R4: In modes 2 and 3 with bit 18 clear, a divider N of zero gives a period of 4 source cycles, and a nonzero N gives a period of 8·N source cycles.
- R5: In mode 3 with bit 18 set, the period is 2 source cycles whatever the divider value. In modes 0 and 2, bit 18 has no effect on the period.
- R6: A write that changes any of the three fields reads back the stable flag as 0 from the edge that takes the write. A write that leaves all three fields unchanged does not clear the flag.
- R7: After a changing write, the stable flag stays 0 for at least two periods of the new setting. It returns to 1 within one old period plus three new periods. A second write that arrives before the first has taken effect replaces it.
- R8: Setting changes take effect only at the end of a card clock low phase. Every high pulse therefore lasts exactly one half period of either the old setting or the new setting.
- R9: While reset is asserted, the card clock is low, the stable flag is 0 and the read-back word is zero. After reset the block runs in mode 0 with divider 0 (period 2) and reports stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration write word |
| cfgRdData | output | 32 | Read-back word: fields as written plus stable flag |
| cardClk | output | 1 | Card bus clock |
| clkStable | output | 1 | Clock-stable flag (also bit 7 of read-back) |

## Verification
The hardest case to reach is a pending setting that is replaced before it ever takes effect. This needs a slow current clock, so that a long wait separates the write from the next low-phase boundary. The stimulus first selects the slowest double-data-rate divider. It then issues two writes a few cycles apart and checks the following: the intermediate setting never produces a high pulse, the final period matches the second write, and the stable flag stays low throughout. Entering and leaving bypass are reached from the vector walk, which places bypass entries between divided ones.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  localparam int CK_DIV_W  = 8;
  localparam int CK_HALF_W = CK_DIV_W + 2;
  localparam int CK_WORD_W = 32;
  localparam int CK_STB_BIT  = 7;
  localparam int CK_DIV_LSB  = 8;
  localparam int CK_MODE_LSB = 16;
  localparam int CK_HS_BIT   = 18;

  typedef enum logic [1:0] {
    CK_SDR_DIV  = 2'd0,
    CK_BYPASS   = 2'd1,
    CK_DDR_DIV  = 2'd2,
    CK_DDR_FAST = 2'd3
  } ck_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic                 pendValid;
    logic                 pendBypass;
    logic [CK_HALF_W-1:0] pendHalf;
  } ck_cmd_t;

  // datapath -> control strobes
  typedef struct packed {
    logic boundary;
    logic applied;
  } ck_evt_t;

  // half period in source cycles for a given field set
  function automatic ck_cmd_t ckMap(input ck_mode_e mode,
                                    input logic [CK_DIV_W-1:0] div,
                                    input logic hs);
    ck_cmd_t r;
    logic [CK_HALF_W-1:0] divExt;
    divExt       = CK_HALF_W'(div);
    r.pendValid  = 1'b1;
    r.pendBypass = 1'b0;
    r.pendHalf   = CK_HALF_W'(1);
    case (mode)
      CK_SDR_DIV:  r.pendHalf = (div == '0) ? CK_HALF_W'(1) : (divExt << 1);
      CK_BYPASS:   r.pendBypass = 1'b1;
      CK_DDR_DIV:  r.pendHalf = (div == '0) ? CK_HALF_W'(2) : (divExt << 2);
      CK_DDR_FAST: begin
        if (hs) r.pendHalf = CK_HALF_W'(1);
        else    r.pendHalf = (div == '0) ? CK_HALF_W'(2) : (divExt << 2);
      end
      default: r.pendHalf = CK_HALF_W'(1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrMode,
  input  logic [CK_DIV_W-1:0] wrDiv,
  input  logic                wrHs,
  input  ck_evt_t             evt,
  output ck_cmd_t             cmd,
  output logic [1:0]          curMode,
  output logic [CK_DIV_W-1:0] curDiv,
  output logic                curHs,
  output logic                clkStable
);

  logic       fieldsDiffer;
  logic       actBypass;
  logic [1:0] remain;
  ck_cmd_t    mapped;

  assign fieldsDiffer = (wrMode != curMode) || (wrDiv != curDiv) || (wrHs != curHs);
  assign mapped       = ckMap(ck_mode_e'(wrMode), wrDiv, wrHs);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode   <= 2'd0;
      curDiv    <= '0;
      curHs     <= 1'b0;
      cmd       <= ckMap(CK_SDR_DIV, '0, 1'b0);
      actBypass <= 1'b0;
      remain    <= 2'd2;
      clkStable <= 1'b0;
    end else begin
      if (evt.applied) actBypass <= cmd.pendBypass;
      if (wrEn && fieldsDiffer) begin
        curMode   <= wrMode;
        curDiv    <= wrDiv;
        curHs     <= wrHs;
        cmd       <= mapped;
        clkStable <= 1'b0;
      end else if (evt.applied) begin
        cmd.pendValid <= 1'b0;
        // leaving bypass starts with a lone low phase: wait one extra boundary
        remain <= (actBypass && !cmd.pendBypass) ? 2'd3 : 2'd2;
      end else if (evt.boundary && !cmd.pendValid && !clkStable) begin
        if (remain == 2'd1) clkStable <= 1'b1;
        remain <= remain - 2'd1;
      end
    end
  end

endmodule

// File: rtl/cardclk_dp.sv
module cardclk_dp
  import cardclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  ck_cmd_t cmd,
  output ck_evt_t evt,
  output logic    divClk,
  output logic    bypassNeg
);

  logic [CK_HALF_W-1:0] cnt;
  logic [CK_HALF_W-1:0] halfAct;
  logic                 bypassPos;
  logic                 termHit;

  assign termHit = (cnt == halfAct - CK_HALF_W'(1));

  always_comb begin
    evt.boundary = bypassPos ? 1'b1 : (!divClk && termHit);
    evt.applied  = evt.boundary && cmd.pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      halfAct   <= CK_HALF_W'(1);
      bypassPos <= 1'b0;
      divClk    <= 1'b0;
    end else if (evt.applied) begin
      cnt       <= '0;
      halfAct   <= cmd.pendHalf;
      bypassPos <= cmd.pendBypass;
      divClk    <= !cmd.pendBypass && !bypassPos;
    end else if (bypassPos) begin
      cnt    <= '0;
      divClk <= 1'b0;
    end else if (termHit) begin
      cnt    <= '0;
      divClk <= !divClk;
    end else begin
      cnt <= cnt + CK_HALF_W'(1);
    end
  end

  // bypass select moves while the source clock is low and divClk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) bypassNeg <= 1'b0;
    else       bypassNeg <= bypassPos;
  end

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CK_WORD_W-1:0] cfgWrData,
  output logic [CK_WORD_W-1:0] cfgRdData,
  output logic                 cardClk,
  output logic                 clkStable
);

  ck_cmd_t             cmd;
  ck_evt_t             evt;
  logic                divClk;
  logic                bypassNeg;
  logic [1:0]          curMode;
  logic [CK_DIV_W-1:0] curDiv;
  logic                curHs;
  logic                unusedWrBits;

  assign unusedWrBits = ^{cfgWrData[CK_WORD_W-1:CK_HS_BIT+1], cfgWrData[CK_DIV_LSB-1:0]};

  cardclk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (cfgWrEn),
    .wrMode    (cfgWrData[CK_MODE_LSB +: 2]),
    .wrDiv     (cfgWrData[CK_DIV_LSB +: CK_DIV_W]),
    .wrHs      (cfgWrData[CK_HS_BIT]),
    .evt       (evt),
    .cmd       (cmd),
    .curMode   (curMode),
    .curDiv    (curDiv),
    .curHs     (curHs),
    .clkStable (clkStable)
  );

  cardclk_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .evt       (evt),
    .divClk    (divClk),
    .bypassNeg (bypassNeg)
  );

  assign cardClk = bypassNeg ? clk : divClk;

  always_comb begin
    cfgRdData                          = '0;
    cfgRdData[CK_STB_BIT]              = clkStable;
    cfgRdData[CK_DIV_LSB +: CK_DIV_W]  = curDiv;
    cfgRdData[CK_MODE_LSB +: 2]        = curMode;
    cfgRdData[CK_HS_BIT]               = curHs;
  end

endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [31:0] cfgWrData,
  input logic [31:0] cfgRdData,
  input logic        clkStable,
  input logic        divClk,
  input logic        bypassNeg,
  input logic        pendValid,
  input logic        applied
);

  logic fieldsSame;
  assign fieldsSame = (cfgWrData[18:8] == cfgRdData[18:8]);

  a_r6_change_drops_stable: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && !fieldsSame |=> !clkStable);

  a_r6_same_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && fieldsSame && clkStable |=> clkStable);

  a_r8_apply_in_low: assert property (@(posedge clk) disable iff (!rstN)
    applied |-> !divClk);

  a_r2_bypass_div_quiet: assert property (@(posedge clk) disable iff (!rstN)
    bypassNeg |-> !divClk);

  a_r7_stable_no_pending: assert property (@(posedge clk) disable iff (!rstN)
    clkStable |-> !pendValid);

endmodule

bind cardclk_gen cardclk_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .cfgRdData (cfgRdData),
  .clkStable (clkStable),
  .divClk    (divClk),
  .bypassNeg (bypassNeg),
  .pendValid (cmd.pendValid),
  .applied   (evt.applied)
);

// File: tb/sim_cardclk_gen.sv
module sim_cardclk_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cardClk;
  logic        clkStable;

  always #2 clk = ~clk;   // 250 MHz

  cardclk_gen u0 (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .cardClk   (cardClk),
    .clkStable (clkStable)
  );

  int  nChecks = 0;
  int  nErr = 0;
  int  edges = 0;
  int  runLen = 0;
  int  allowA = 1;
  int  allowB = 1;
  bit  monOn = 1'b0;
  bit  finished = 1'b0;

  // {mode, divider, half-rate, expected period}
  localparam logic [22:0] VEC [15] = '{
    {2'd0, 8'd1,   1'b0, 12'd4},
    {2'd0, 8'd3,   1'b0, 12'd12},
    {2'd1, 8'd5,   1'b0, 12'd1},
    {2'd2, 8'd0,   1'b0, 12'd4},
    {2'd2, 8'd1,   1'b0, 12'd8},
    {2'd0, 8'd0,   1'b1, 12'd2},
    {2'd2, 8'd1,   1'b1, 12'd8},
    {2'd3, 8'd0,   1'b0, 12'd4},
    {2'd3, 8'd3,   1'b0, 12'd24},
    {2'd3, 8'd7,   1'b1, 12'd2},
    {2'd1, 8'd0,   1'b0, 12'd1},
    {2'd0, 8'd2,   1'b1, 12'd8},
    {2'd2, 8'd255, 1'b0, 12'd2040},
    {2'd0, 8'd255, 1'b0, 12'd1020},
    {2'd3, 8'd255, 1'b1, 12'd2}
  };

  always @(posedge cardClk) edges++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R8: every high pulse equals a half period of the old or new setting
  always @(negedge clk) begin
    #1;
    if (monOn) begin
      if (cardClk) runLen++;
      else if (runLen > 0) begin
        chk(runLen == allowA || runLen == allowB, "R8 high pulse", runLen, allowA);
        runLen = 0;
      end
    end else runLen = 0;
  end

  task automatic writeCfg(input logic [1:0] m, input logic [7:0] n, input logic h);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrData = {13'd0, h, m, n, 8'd0};
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  task automatic waitStable(output int cyc);
    cyc = 0;
    while (!clkStable && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic measure(input int p, input string req);
    @(negedge clk);
    #1;
    edges = 0;
    repeat (8 * p) @(negedge clk);
    #1;
    chk(edges == 8, req, edges, 8);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    int cyc;
    int oldP;
    logic [1:0] m;
    logic [7:0] n;
    logic h;
    logic [11:0] p;
    string tag;

    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(cardClk == 1'b0, "R9 clock low in reset", int'(cardClk), 0);
    chk(clkStable == 1'b0, "R9 stable low in reset", int'(clkStable), 0);
    chk(cfgRdData == 32'd0, "R9 readback zero in reset", int'(cfgRdData), 0);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    waitStable(cyc);
    chk(clkStable == 1'b1, "R9 stable after reset", int'(clkStable), 1);
    measure(2, "R9 default period");
    oldP = 2;

    // vector walk: R1..R7
    for (int i = 0; i < 15; i++) begin
      {m, n, h, p} = VEC[i];
      allowB = allowA;
      allowA = int'(p) / 2;
      writeCfg(m, n, h);
      #1;
      chk(clkStable == 1'b0, "R6 changing write clears stable", int'(clkStable), 0);
      chk(cfgRdData == {13'd0, h, m, n, 8'd0}, "R1 readback fields",
          int'(cfgRdData), int'({13'd0, h, m, n, 8'd0}));
      waitStable(cyc);
      chk(cyc >= 2 * int'(p), "R7 stable not early", cyc, 2 * int'(p));
      chk(cyc <= oldP + 3 * int'(p) + 4, "R7 stable not late", cyc, oldP + 3 * int'(p) + 4);
      if (h && m != 2'd3)  tag = "R5 half-rate ignored";
      else if (m == 2'd1)  tag = "R2 bypass period";
      else if (m == 2'd3 && h) tag = "R5 half-rate period";
      else if (m == 2'd0)  tag = "R3 sdr period";
      else                 tag = "R4 ddr period";
      measure(int'(p), tag);
      oldP = int'(p);
    end

    // R6: identical write keeps stable
    writeCfg(2'd3, 8'd255, 1'b1);
    #1;
    chk(clkStable == 1'b1, "R6 same write keeps stable", int'(clkStable), 1);
    measure(2, "R6 period unchanged");

    // R7/R8: pending setting replaced before it is applied
    allowB = 1;
    allowA = 1020;
    writeCfg(2'd2, 8'd255, 1'b0);
    waitStable(cyc);
    allowB = 1020;
    allowA = 4;
    writeCfg(2'd0, 8'd1, 1'b0);
    repeat (5) @(negedge clk);
    writeCfg(2'd0, 8'd2, 1'b0);
    #1;
    chk(clkStable == 1'b0, "R7 stable low while pending", int'(clkStable), 0);
    chk(cfgRdData == {13'd0, 1'b0, 2'd0, 8'd2, 8'd0}, "R1 readback last write",
        int'(cfgRdData), int'({13'd0, 1'b0, 2'd0, 8'd2, 8'd0}));
    waitStable(cyc);
    chk(clkStable == 1'b1, "R7 stable after replacement", int'(clkStable), 1);
    measure(8, "R7 replaced setting period");

    // R9: reset while running
    monOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(cardClk == 1'b0, "R9 clock low in mid-run reset", int'(cardClk), 0);
    chk(cfgRdData == 32'd0, "R9 readback cleared", int'(cfgRdData), 0);
    @(negedge clk);
    rstN = 1'b1;
    waitStable(cyc);
    measure(2, "R9 period after mid-run reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule